// File: doc/BRIEF.md
# Triple Interval Timer

This block places three independent down-counters behind a single register bus. Each counter has its own 256-byte window of registers and drives its own interrupt line. A counter advances only when its tick-enable input is high. The tick then passes through a per-timer prescaler that divides by 1, 16 or 256. Timer 0 is normally fed from a faster tick than timers 1 and 2, but the block treats all three tick inputs the same way.

Each timer runs in one of three modes:
- **One-shot:** the timer fires once and then parks at zero.
- **Periodic:** the timer reloads from a limit register.
- **Free-running:** the timer wraps to all-ones at 16 or 32 bits.

On expiry the timer sets a raw interrupt flag. An enable bit in the control word gates that flag onto the output line. Software can change the limit in two ways. A load write also restarts the count. A background-load write leaves the running period alone.

Register writes take effect at the next clock edge. Reads are combinational from the current state. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `triple_timer`

## Requirements
- R1: The bus address selects timer `addr[9:8]` and register index `addr[7:2]`. A read of timer window 3, or of an index outside {0,1,2,4,5,6}, returns 0.
- R2: A write to index 0 (load) sets both the limit and the current count and restarts the prescaler. A write to index 6 (background load) changes only the limit. A read of index 0 or 6 returns the limit.
- R3: Index 1 reads the current count. Writes to index 1 change nothing.
- R4: The control word at index 2 is 8 bits wide: bit 7 run, bit 6 periodic, bit 5 interrupt enable, bits 3:2 prescale, bit 1 32-bit wrap, bit 0 one-shot. After reset, control reads 0x20, count reads 0xFFFFFFFF, limit reads 0, raw status reads 0, and all irq lines are low.
- R5: While run (bit 7) is 0, the count holds its value whatever the tick inputs do.
- R6: With run set, one count step is taken every 1 enabled tick (prescale 00 or 11), every 16 ticks (01) or every 256 ticks (10). A write to control or load restarts the prescaler.
- R7: A step taken when the count is 1, or 0 outside one-shot mode, is an expiry. An expiry sets raw status (index 4, bit 0). In periodic mode it reloads the count from the limit. Otherwise, a step decrements the count.
- R8: In free-running mode (bit 6 = 0, bit 0 = 0) an expiry reloads 0xFFFFFFFF when bit 1 is 1, and 0x0000FFFF when bit 1 is 0.
- R9: In one-shot mode an expiry leaves the count at 0. Further ticks then cause no further expiry and no count change.
- R10: Masked status (index 5, bit 0) and the timer's irq output both equal raw status AND control bit 5.
- R11: A write of any value to index 3 clears raw status. An expiry in the same cycle wins, and raw status stays set.
- R12: Each timer counts only on its own tick input and is written only through its own window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 10 | Byte address; bits 9:8 select the timer, bits 7:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| tick_en | input | 3 | Per-timer count tick enable |
| irq | output | 3 | Per-timer masked interrupt |

## Verification
Any fault in the counting state appears at the ports at the next clock edge:
- A wrong count, limit or prescaler phase changes the value read at index 1.
- A wrong expiry decision moves the raw flag, and with interrupts enabled it also moves the irq line.

The bench's reference model is compared against the read port and all three irq lines on every clock, so a disagreement is reported in the cycle it first becomes visible. A prescaler fault stays hidden until the next step is due: up to 256 ticks later at the largest divide. For that reason, the directed part of the bench probes the count one tick before and one tick after a 16-tick step boundary.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Register index inside one timer window (byte offset >> 2).
  typedef enum logic [5:0] {
    IDX_LOAD  = 6'd0,
    IDX_VALUE = 6'd1,
    IDX_CTRL  = 6'd2,
    IDX_ICLR  = 6'd3,
    IDX_RAW   = 6'd4,
    IDX_MSK   = 6'd5,
    IDX_BGLD  = 6'd6
  } reg_idx_e;

  // Control word, MSB first.
  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       irq_en;
    logic       spare;
    logic [1:0] psc;
    logic       wide;
    logic       single;
  } tmr_ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'h20;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] psc,
  output logic       step
);

  localparam logic [DIV_W-1:0] MAX_BY16  = DIV_W'(15);
  localparam logic [DIV_W-1:0] MAX_BY256 = DIV_W'(255);

  logic [DIV_W-1:0] div_q, div_d, div_max;

  always_comb begin
    case (psc)
      2'b01:   div_max = MAX_BY16;
      2'b10:   div_max = MAX_BY256;
      default: div_max = '0;
    endcase
  end

  always_comb begin
    div_d = div_q;
    step  = 1'b0;
    if (restart) begin
      div_d = '0;
    end else if (tick && run) begin
      if (div_q == div_max) begin
        div_d = '0;
        step  = 1'b1;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // After any step the divider starts a fresh period.
  assert_step_rewinds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (div_q == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam logic [CNT_W-1:0] WRAP_WIDE   = '1;
  localparam logic [CNT_W-1:0] WRAP_NARROW = CNT_W'(17'h0FFFF);
  localparam logic [CNT_W-1:0] CNT_ONE     = CNT_W'(1);

  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] limit_q, limit_d;
  logic             raw_q, raw_d;
  logic             step, expire;
  logic             ld_wr, val_wr, ctl_wr, clr_wr, bg_wr;
  reg_idx_e         idx_e;

  assign idx_e  = reg_idx_e'(idx);
  assign ld_wr  = wr_en && (idx_e == IDX_LOAD);
  assign val_wr = wr_en && (idx_e == IDX_VALUE);
  assign ctl_wr = wr_en && (idx_e == IDX_CTRL);
  assign clr_wr = wr_en && (idx_e == IDX_ICLR);
  assign bg_wr  = wr_en && (idx_e == IDX_BGLD);

  tmr_prescale #(.DIV_W(DIV_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (ctrl_q.run),
    .restart (ld_wr || ctl_wr),
    .psc     (ctrl_q.psc),
    .step    (step)
  );

  // Next-state logic
  always_comb begin
    count_d = count_q;
    limit_d = limit_q;
    ctrl_d  = ctrl_q;
    raw_d   = raw_q;
    expire  = 1'b0;

    if (step && !(ctrl_q.single && count_q == '0) && count_q <= CNT_ONE)
      expire = 1'b1;

    if (ld_wr) begin
      count_d = wdata[CNT_W-1:0];
    end else if (step) begin
      if (expire) begin
        if (ctrl_q.single)        count_d = '0;
        else if (ctrl_q.periodic) count_d = limit_q;
        else if (ctrl_q.wide)     count_d = WRAP_WIDE;
        else                      count_d = WRAP_NARROW;
      end else if (count_q != '0) begin
        count_d = count_q - 1'b1;
      end
    end

    if (ld_wr || bg_wr) limit_d = wdata[CNT_W-1:0];
    if (ctl_wr)         ctrl_d  = tmr_ctrl_t'(wdata[7:0]);

    if (expire)      raw_d = 1'b1;
    else if (clr_wr) raw_d = 1'b0;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= tmr_ctrl_t'(CTRL_RESET);
      count_q <= '1;
      limit_q <= '0;
      raw_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      count_q <= count_d;
      limit_q <= limit_d;
      raw_q   <= raw_d;
    end
  end

  // Read mux
  always_comb begin
    rdata = '0;
    case (idx_e)
      IDX_LOAD,
      IDX_BGLD:  rdata = DATA_W'(limit_q);
      IDX_VALUE: rdata = DATA_W'(count_q);
      IDX_CTRL:  rdata[7:0] = ctrl_q;
      IDX_RAW:   rdata[0] = raw_q;
      IDX_MSK:   rdata[0] = raw_q & ctrl_q.irq_en;
      default:   rdata = '0;
    endcase
  end

  assign irq = raw_q & ctrl_q.irq_en;

  assert_load_sets_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> (count_q == $past(wdata[CNT_W-1:0])));

  assert_value_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (val_wr && !step) |=> (count_q == $past(count_q)) && (limit_q == $past(limit_q)));

  assert_hold_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !ld_wr) |=> $stable(count_q));

  assert_raw_needs_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $past(step));

  assert_single_parks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.single && count_q == '0 && !ld_wr) |=> (count_q == '0));

  assert_clear_drops_raw_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire) |=> !raw_q);

endmodule

// File: rtl/triple_timer.sv
module triple_timer #(
  parameter int NUM_TMR   = 3,
  parameter int CNT_W     = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 10,
  parameter int WIN_BYTES = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_TMR-1:0]  tick_en,
  output logic [NUM_TMR-1:0]  irq
);

  localparam int WIN_BITS = $clog2(WIN_BYTES);
  localparam int CH_W     = ADDR_W - WIN_BITS;
  localparam int IDX_W    = WIN_BITS - 2;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [CH_W-1:0]   chan_sel;
  logic [IDX_W-1:0]  reg_idx;
  logic [DATA_W-1:0] ch_rdata [NUM_TMR];
  logic              unused_addr_lsb;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign chan_sel        = bus_addr[ADDR_W-1:WIN_BITS];
  assign reg_idx         = bus_addr[WIN_BITS-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];

  for (genvar c = 0; c < NUM_TMR; c++) begin : g_tmr
    tmr_channel #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
    ) u_chan (
      .clk   (clk),
      .rst_n (rst_int_n),
      .tick  (tick_en[c]),
      .wr_en (bus_sel && bus_wr && (chan_sel == CH_W'(c))),
      .idx   (reg_idx),
      .wdata (bus_wdata),
      .rdata (ch_rdata[c]),
      .irq   (irq[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_TMR; c++) begin
      if (chan_sel == CH_W'(c)) bus_rdata = ch_rdata[c];
    end
  end

endmodule

// File: tb/triple_timer_test.sv
module triple_timer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2:0]  tick_en, irq;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  logic [31:0] m_cnt [3];
  logic [31:0] m_lim [3];
  logic [7:0]  m_ctrl[3];
  logic        m_raw [3];
  int          m_div [3];

  always #4 clk = ~clk;

  triple_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_en   (tick_en),
    .irq       (irq)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic logic [31:0] model_read(input logic [9:0] a);
    int c  = int'(a[9:8]);
    int ix = int'(a[7:2]);
    if (c > 2) return 32'h0;
    case (ix)
      0, 6:    return m_lim[c];
      1:       return m_cnt[c];
      2:       return {24'h0, m_ctrl[c]};
      4:       return {31'h0, m_raw[c]};
      5:       return {31'h0, m_raw[c] & m_ctrl[c][5]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    for (int c = 0; c < 3; c++) begin
      bit sel, ldw, ctw, clw, bgw, stp, fire;
      int ix, dmax;
      sel  = bus_sel && bus_wr && (int'(bus_addr[9:8]) == c);
      ix   = int'(bus_addr[7:2]);
      ldw  = sel && ix == 0;
      ctw  = sel && ix == 2;
      clw  = sel && ix == 3;
      bgw  = sel && ix == 6;
      dmax = (m_ctrl[c][3:2] == 2'b01) ? 15 : (m_ctrl[c][3:2] == 2'b10) ? 255 : 0;
      stp  = 0;
      fire = 0;
      if (ldw || ctw) m_div[c] = 0;
      else if (tick_en[c] && m_ctrl[c][7]) begin
        if (m_div[c] == dmax) begin m_div[c] = 0; stp = 1; end
        else m_div[c]++;
      end
      if (stp && !(m_ctrl[c][0] && m_cnt[c] == 0)) begin
        if (m_cnt[c] <= 1) begin
          fire = 1;
          if (m_ctrl[c][0])      m_cnt[c] = 0;
          else if (m_ctrl[c][6]) m_cnt[c] = m_lim[c];
          else if (m_ctrl[c][1]) m_cnt[c] = 32'hFFFF_FFFF;
          else                   m_cnt[c] = 32'h0000_FFFF;
        end else m_cnt[c] = m_cnt[c] - 1;
      end
      if (ldw)        m_cnt[c]  = bus_wdata;
      if (ldw || bgw) m_lim[c]  = bus_wdata;
      if (ctw)        m_ctrl[c] = bus_wdata[7:0];
      if (fire)       m_raw[c]  = 1'b1;
      else if (clw)   m_raw[c]  = 1'b0;
    end
  endtask

  // One clock: compare the state left by the last edge, then drive the next inputs.
  task automatic cyc(input bit wr, input int ch, input int idx,
                     input logic [31:0] d, input logic [2:0] tk, input string tag);
    @(negedge clk);
    check({29'h0, irq}, {29'h0, m_raw[2] & m_ctrl[2][5], m_raw[1] & m_ctrl[1][5],
                         m_raw[0] & m_ctrl[0][5]}, {tag, " irq (R10)"});
    check(bus_rdata, model_read(bus_addr), {tag, " rdata"});
    bus_sel   = wr;
    bus_wr    = wr;
    bus_addr  = 10'(ch * 256 + idx * 4);
    bus_wdata = d;
    tick_en   = tk;
    model_step();
  endtask

  // Read a register after the next (idle) edge and compare with a fixed value.
  task automatic peek(input int ch, input int idx, input logic [31:0] exp, input string tag);
    cyc(0, ch, idx, 32'h0, 3'b000, tag);
    @(posedge clk);
    #2;
    check(bus_rdata, exp, tag);
  endtask

  task automatic ticks(input int n, input logic [2:0] tk, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 32'h0, tk, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; tick_en = '0;
    for (int c = 0; c < 3; c++) begin
      m_cnt[c] = 32'hFFFF_FFFF; m_lim[c] = 0; m_ctrl[c] = 8'h20; m_raw[c] = 0; m_div[c] = 0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 reset state
    peek(0, 2, 32'h20, "R4 ctrl reset");
    peek(1, 1, 32'hFFFF_FFFF, "R4 count reset");
    peek(2, 0, 32'h0, "R4 limit reset");
    check({29'h0, irq}, 32'h0, "R4 irq reset");
    // R1 decode holes
    peek(3, 1, 32'h0, "R1 window 3");
    peek(0, 7, 32'h0, "R1 unused index");
    // R2 load / background load
    cyc(1, 0, 0, 32'd5, 3'b000, "R2");
    peek(0, 1, 32'd5, "R2 load count");
    cyc(1, 0, 6, 32'd9, 3'b000, "R2");
    peek(0, 1, 32'd5, "R2 bg keeps count");
    peek(0, 0, 32'd9, "R2 bg limit");
    // R3 value write ignored
    cyc(1, 0, 1, 32'd77, 3'b000, "R3");
    peek(0, 1, 32'd5, "R3 value read-only");
    // R5 stopped timer holds
    ticks(4, 3'b111, "R5");
    peek(0, 1, 32'd5, "R5 hold");
    // R7 periodic expiry reloads limit
    cyc(1, 0, 2, 32'hE0, 3'b000, "R7");
    ticks(5, 3'b001, "R7");
    peek(0, 1, 32'd9, "R7 reload");
    peek(0, 4, 32'd1, "R7 raw");
    peek(0, 5, 32'd1, "R10 masked on");
    // R10 mask off
    cyc(1, 0, 2, 32'hC0, 3'b000, "R10");
    peek(0, 5, 32'd0, "R10 masked off");
    peek(0, 4, 32'd1, "R10 raw kept");
    // R11 clear
    cyc(1, 0, 3, 32'h1234, 3'b000, "R11");
    peek(0, 4, 32'd0, "R11 clear");
    // R8 free-running wrap
    cyc(1, 1, 2, 32'h80, 3'b000, "R8");
    cyc(1, 1, 0, 32'd2, 3'b000, "R8");
    ticks(2, 3'b010, "R8");
    peek(1, 1, 32'h0000_FFFF, "R8 narrow wrap");
    cyc(1, 1, 2, 32'h82, 3'b000, "R8");
    cyc(1, 1, 0, 32'd1, 3'b000, "R8");
    ticks(1, 3'b010, "R8");
    peek(1, 1, 32'hFFFF_FFFF, "R8 wide wrap");
    // R9 one-shot
    cyc(1, 2, 0, 32'd2, 3'b000, "R9");
    cyc(1, 2, 2, 32'hA1, 3'b000, "R9");
    ticks(5, 3'b100, "R9");
    peek(2, 1, 32'd0, "R9 parked");
    cyc(1, 2, 3, 32'd0, 3'b000, "R9");
    ticks(3, 3'b100, "R9");
    peek(2, 4, 32'd0, "R9 no refire");
    // R6 prescale by 16
    cyc(1, 0, 2, 32'hC4, 3'b000, "R6");
    cyc(1, 0, 0, 32'd2, 3'b000, "R6");
    ticks(31, 3'b001, "R6");
    peek(0, 1, 32'd1, "R6 before boundary");
    ticks(1, 3'b001, "R6");
    peek(0, 1, 32'd2, "R6 at boundary");
    // R11 expiry beats clear
    cyc(1, 1, 2, 32'hC0, 3'b000, "R11");
    cyc(1, 1, 0, 32'd1, 3'b000, "R11");
    cyc(1, 1, 3, 32'd0, 3'b010, "R11");
    peek(1, 4, 32'd1, "R11 expiry wins");

    // R12 random traffic, model compared every clock
    for (int n = 0; n < 30000; n++) begin
      bit          wr;
      int          ch, idx;
      logic [31:0] d;
      logic [2:0]  tk;
      wr  = ($urandom % 10) == 0;
      ch  = $urandom % 4;
      idx = $urandom % 7;
      if (idx == 2) d = {24'h0, ($urandom % 4 != 0), 7'($urandom)};
      else          d = ($urandom % 8 == 0) ? $urandom : ($urandom % 40);
      tk  = {($urandom % 3 == 0), ($urandom % 3 == 0), ($urandom % 4 != 0)};
      cyc(wr, ch, idx, d, tk, "R12");
    end
    cyc(0, 0, 1, 32'h0, 3'b000, "R12");

    summary();
    $finish;
  end

endmodule